// File: doc/BRIEF.md
# Iterative Multi-Mode Multiplier

This block multiplies two 32-bit operands with a shift-and-add loop and supports six multiply variants, chosen by a 3-bit opcode. The short forms return the low 32 bits of the product, with or without a 32-bit addend. The long forms return the full 64-bit product as a high and a low word, unsigned or signed, with or without a 64-bit addend supplied as a high:low pair. When the caller asks for it, the block also updates a negative flag and a zero flag from the result.

A caller sets the operands, the opcode and the flag-update bit, then pulses `start` while `busy` is low. Inputs are sampled only on that edge. `done` pulses once when the result registers hold the answer. Two opcodes are not assigned. Starting with either of them raises `err` for one cycle, and the results and flags stay as they were.

Top module: `seqmul_unit`

## Requirements
- R1: Opcode 3'b000 gives `res_lo` = bits 31:0 of a*b, with `res_hi` = 0.
- R2: Opcode 3'b001 gives `res_lo` = bits 31:0 of a*b + `acc_in`, with `res_hi` = 0.
- R3: Opcode 3'b100 gives the unsigned 64-bit product a*b as {`res_hi`,`res_lo`}.
- R4: Opcode 3'b101 gives the unsigned product plus {`acc_hi`,`acc_lo`}, modulo 2^64, as {`res_hi`,`res_lo`}.
- R5: Opcode 3'b110 gives the two's-complement 64-bit product of the signed operands. Opcode 3'b111 adds {`acc_hi`,`acc_lo`} to that signed product, modulo 2^64.
- R6: With `set_flags` = 1 at start, the flags are updated on completion. For the long forms (op[2] = 1), `flag_n` = bit 63 and `flag_z` = 1 only when all 64 result bits are zero. For the short forms, `flag_n` = bit 31 and `flag_z` = 1 only when `res_lo` is zero.
- R7: With `set_flags` = 0 at start, `flag_n` and `flag_z` keep their previous values. The flags change only in a `done` cycle.
- R8: Opcodes 3'b010 and 3'b011 raise `err` for exactly one cycle, in the cycle after the start edge. They produce no `done`, and they leave `res_hi`, `res_lo` and the flags unchanged.
- R9: `done` is high for exactly one cycle, 33 clock edges after the accepted start edge. `busy` is high from the accepted start edge until `done` rises.
- R10: A `start` pulse while `busy` is high is ignored. Changes to the operand, opcode and addend inputs after the start edge do not affect the running result.
- R11: During and after synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when not busy |
| op | input | 3 | Multiply variant select |
| set_flags | input | 1 | Update N/Z from this result |
| opnd_a | input | 32 | Multiplicand |
| opnd_b | input | 32 | Multiplier |
| acc_in | input | 32 | Addend for the short accumulate form |
| acc_hi | input | 32 | Upper word of 64-bit addend |
| acc_lo | input | 32 | Lower word of 64-bit addend |
| res_hi | output | 32 | Upper result word (zero for short forms) |
| res_lo | output | 32 | Lower result word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Operation in progress |
| err | output | 1 | One-cycle unassigned-opcode strobe |

## Verification
The hardest condition to reach is a second `start` arriving mid-iteration while the operand inputs have already moved on. Such a start must neither restart the loop nor leak into the product. The stimulus scrambles every operand input right after each accepted start edge, and in one directed run it also pulses `start` with a different opcode several cycles into the loop. The expected result and the 33-edge latency are then compared against the original operands. Signed corner products, such as the most negative value times itself and times the most positive value, are placed in the vector table alongside additions that wrap to zero, so that the subtract-on-sign-bit step and the 64-bit zero flag are both exercised.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'b000,
    OP_MLA   = 3'b001,
    OP_RSV2  = 3'b010,
    OP_RSV3  = 3'b011,
    OP_UMULL = 3'b100,
    OP_UMLAL = 3'b101,
    OP_SMULL = 3'b110,
    OP_SMLAL = 3'b111
  } mop_e;

  typedef struct packed {
    logic legal;
    logic is_long;
    logic is_signed;
    logic adds;
  } mop_attr_t;

  function automatic mop_attr_t decode_op(input logic [2:0] op);
    mop_attr_t r;
    r.legal     = op[2] | ~op[1];
    r.is_long   = op[2];
    r.is_signed = op[2] & op[1];
    r.adds      = op[0];
    return r;
  endfunction

endpackage

// File: rtl/imul_decode.sv
module imul_decode
  import imul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]     op,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   acc_hi,
  input  logic [W-1:0]   acc_lo,
  output mop_attr_t      attr,
  output logic [2*W-1:0] mcand,
  output logic [W-1:0]   mplier,
  output logic [2*W-1:0] addend
);
  localparam int PW = 2 * W;

  always_comb begin
    attr   = decode_op(op);
    mplier = opnd_b;
    if (attr.is_signed) mcand = {{W{opnd_a[W-1]}}, opnd_a};
    else                mcand = {{W{1'b0}}, opnd_a};
    if (!attr.adds)        addend = '0;
    else if (attr.is_long) addend = {acc_hi, acc_lo};
    else                   addend = PW'(acc_in);
  end

endmodule

// File: rtl/imul_core.sv
module imul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           sgn_in,
  input  logic [2*W-1:0] mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod,
  output logic           running,
  output logic           fin
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;
  logic [PW-1:0] prod_q;
  logic [CW-1:0] cnt_q;
  logic          sgn_q;
  logic          run_q;
  logic          fin_q;

  logic          last;
  logic [PW-1:0] step_val;

  // The top multiplier bit of a signed operand carries negative weight.
  always_comb begin
    last = (cnt_q == LAST);
    if (!mplier_q[0])        step_val = prod_q;
    else if (last && sgn_q)  step_val = prod_q - mcand_q;
    else                     step_val = prod_q + mcand_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
      cnt_q    <= '0;
      sgn_q    <= 1'b0;
      run_q    <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        mcand_q  <= mcand_in;
        mplier_q <= mplier_in;
        prod_q   <= '0;
        cnt_q    <= '0;
        sgn_q    <= sgn_in;
        run_q    <= 1'b1;
      end else if (run_q) begin
        prod_q   <= step_val;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + 1'b1;
        if (last) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign prod    = prod_q;
  assign running = run_q;
  assign fin     = fin_q;

endmodule

// File: rtl/imul_finish.sv
module imul_finish #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  logic [2*W-1:0] addend,
  input  logic           is_long,
  output logic [W-1:0]   out_hi,
  output logic [W-1:0]   out_lo,
  output logic           neg,
  output logic           zero
);
  localparam int PW = 2 * W;

  logic [PW-1:0] sum;

  always_comb begin
    sum = prod + addend;
    if (is_long) begin
      out_hi = sum[PW-1:W];
      out_lo = sum[W-1:0];
      neg    = sum[PW-1];
      zero   = (sum == '0);
    end else begin
      out_hi = '0;
      out_lo = sum[W-1:0];
      neg    = sum[W-1];
      zero   = (sum[W-1:0] == '0);
    end
  end

endmodule

// File: rtl/seqmul_unit.sv
module seqmul_unit
  import imul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic         set_flags,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_n,
  output logic         flag_z,
  output logic         done,
  output logic         busy,
  output logic         err
);
  localparam int PW = 2 * W;

  mop_attr_t     attr;
  logic [PW-1:0] mcand_d;
  logic [W-1:0]  mplier_d;
  logic [PW-1:0] addend_d;

  logic [PW-1:0] addend_q;
  logic          long_q;
  logic          flen_q;

  logic [PW-1:0] prod;
  logic          running;
  logic          fin;

  logic [W-1:0]  fin_hi;
  logic [W-1:0]  fin_lo;
  logic          fin_n;
  logic          fin_z;

  logic          accept;
  logic          load;

  logic [W-1:0]  res_hi_q;
  logic [W-1:0]  res_lo_q;
  logic          flag_n_q;
  logic          flag_z_q;
  logic          done_q;
  logic          err_q;

  imul_decode #(.W(W)) u_decode (
    .op     (op),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .acc_in (acc_in),
    .acc_hi (acc_hi),
    .acc_lo (acc_lo),
    .attr   (attr),
    .mcand  (mcand_d),
    .mplier (mplier_d),
    .addend (addend_d)
  );

  assign busy   = running | fin;
  assign accept = start & ~busy;
  assign load   = accept & attr.legal;

  imul_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .sgn_in    (attr.is_signed),
    .mcand_in  (mcand_d),
    .mplier_in (mplier_d),
    .prod      (prod),
    .running   (running),
    .fin       (fin)
  );

  imul_finish #(.W(W)) u_finish (
    .prod    (prod),
    .addend  (addend_q),
    .is_long (long_q),
    .out_hi  (fin_hi),
    .out_lo  (fin_lo),
    .neg     (fin_n),
    .zero    (fin_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addend_q <= '0;
      long_q   <= 1'b0;
      flen_q   <= 1'b0;
      res_hi_q <= '0;
      res_lo_q <= '0;
      flag_n_q <= 1'b0;
      flag_z_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= fin;
      err_q  <= accept & ~attr.legal;
      if (load) begin
        addend_q <= addend_d;
        long_q   <= attr.is_long;
        flen_q   <= set_flags;
      end
      if (fin) begin
        res_hi_q <= fin_hi;
        res_lo_q <= fin_lo;
        if (flen_q) begin
          flag_n_q <= fin_n;
          flag_z_q <= fin_z;
        end
      end
    end
  end

  assign res_hi = res_hi_q;
  assign res_lo = res_lo_q;
  assign flag_n = flag_n_q;
  assign flag_z = flag_z_q;
  assign done   = done_q;
  assign err    = err_q;

endmodule

// File: rtl/seqmul_unit_chk.sv
module seqmul_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [2:0]   op,
  input logic         set_flags,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic         flag_n,
  input logic         flag_z,
  input logic         done,
  input logic         busy,
  input logic         err
);
  localparam int SW = $clog2(W + 3) + 1;
  localparam logic [SW-1:0] LAT = SW'(W + 1);

  logic          acc_ok;
  logic          acc_bad;
  logic          lat_long;
  logic          lat_fl;
  logic [SW-1:0] since_q;

  assign acc_ok  = start && !busy && (op[2] || !op[1]);
  assign acc_bad = start && !busy && !op[2] && op[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_long <= 1'b0;
      lat_fl   <= 1'b0;
      since_q  <= '1;
    end else if (acc_ok) begin
      lat_long <= op[2];
      lat_fl   <= set_flags;
      since_q  <= '0;
    end else if (since_q != '1) begin
      since_q  <= since_q + 1'b1;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_latency_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (since_q == LAT));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !err);

  assert_illegal_holds_R8: assert property (@(posedge clk) disable iff (rst)
    acc_bad |=> (err && !done && $stable(res_hi) && $stable(res_lo)
                 && $stable(flag_n) && $stable(flag_z)));

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(err && done));

  assert_flags_only_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(flag_n) || !$stable(flag_z)) |-> (done && lat_fl));

  assert_long_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (done && lat_fl && lat_long) |->
      (flag_n == res_hi[W-1] && flag_z == (res_hi == '0 && res_lo == '0)));

  assert_short_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (done && lat_fl && !lat_long) |->
      (flag_n == res_lo[W-1] && flag_z == (res_lo == '0)));

  assert_short_hi_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (done && !lat_long) |-> (res_hi == '0));

endmodule

bind seqmul_unit seqmul_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .op        (op),
  .set_flags (set_flags),
  .res_hi    (res_hi),
  .res_lo    (res_lo),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .done      (done),
  .busy      (busy),
  .err       (err)
);

// File: tb/tb_seqmul_unit.sv
`timescale 1ns/1ps
module tb_seqmul_unit;
  localparam int W  = 32;
  localparam int NV = 16;
  localparam int LATENCY = W + 1;

  typedef struct packed {
    logic [2:0]  op;
    logic        fl;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b1, 32'd7,        32'd6,        32'd0,        32'd0,        32'd0},
    '{3'b000, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0,        32'd0,        32'd0},
    '{3'b000, 1'b1, 32'h00010000, 32'h00010000, 32'd0,        32'd0,        32'd0},
    '{3'b001, 1'b1, 32'd3,        32'd5,        32'hFFFFFFF1, 32'd0,        32'd0},
    '{3'b001, 1'b1, 32'h80000000, 32'd1,        32'd0,        32'd0,        32'd0},
    '{3'b100, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0,        32'd0,        32'd0},
    '{3'b100, 1'b1, 32'd0,        32'h12345678, 32'd0,        32'd0,        32'd0},
    '{3'b101, 1'b1, 32'hFFFFFFFF, 32'd2,        32'd0,        32'd0,        32'd2},
    '{3'b101, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0,        32'hFFFFFFFF, 32'hFFFFFFFF},
    '{3'b110, 1'b1, 32'hFFFFFFFF, 32'd1,        32'd0,        32'd0,        32'd0},
    '{3'b110, 1'b1, 32'h80000000, 32'h80000000, 32'd0,        32'd0,        32'd0},
    '{3'b110, 1'b1, 32'h80000000, 32'h7FFFFFFF, 32'd0,        32'd0,        32'd0},
    '{3'b111, 1'b1, 32'hFFFFFFFE, 32'd3,        32'd0,        32'd0,        32'd6},
    '{3'b111, 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0,        32'h80000000, 32'd0},
    '{3'b110, 1'b0, 32'd5,        32'hFFFFFFFD, 32'd0,        32'd0,        32'd0},
    '{3'b101, 1'b0, 32'd0,        32'd0,        32'd0,        32'd0,        32'd0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [2:0]   op = '0;
  logic         set_flags = 1'b0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0, acc_in = '0, acc_hi = '0, acc_lo = '0;
  logic [W-1:0] res_hi, res_lo;
  logic         flag_n, flag_z, done, busy, err;

  int  total = 0;
  int  bad = 0;
  bit  exp_n = 1'b0;
  bit  exp_z = 1'b0;

  always #2.5 clk = ~clk;

  seqmul_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .set_flags(set_flags),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_in(acc_in), .acc_hi(acc_hi),
    .acc_lo(acc_lo), .res_hi(res_hi), .res_lo(res_lo), .flag_n(flag_n),
    .flag_z(flag_z), .done(done), .busy(busy), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string op_req(input logic [2:0] o);
    case (o)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b100:  return "R3";
      3'b101:  return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [63:0] ref_model(input logic [2:0] o, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, input logic [31:0] h, input logic [31:0] l);
    logic [63:0] ua, ub, sa, sb, p;
    ua = {32'd0, a};
    ub = {32'd0, b};
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (o)
      3'b000:  begin p = ua * ub;            return {32'd0, p[31:0]}; end
      3'b001:  begin p = ua * ub + {32'd0, c}; return {32'd0, p[31:0]}; end
      3'b100:  return ua * ub;
      3'b101:  return ua * ub + {h, l};
      3'b110:  return sa * sb;
      default: return sa * sb + {h, l};
    endcase
  endfunction

  task automatic run_op(input logic [2:0] o, input bit fl, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, input logic [31:0] h,
      input logic [31:0] l, input int poke_at);
    logic [63:0] exp_r;
    int n;
    string rq;
    rq = op_req(o);
    exp_r = ref_model(o, a, b, c, h, l);
    if (fl) begin
      exp_n = o[2] ? exp_r[63] : exp_r[31];
      exp_z = o[2] ? (exp_r == 64'd0) : (exp_r[31:0] == 32'd0);
    end
    @(negedge clk);
    op = o; set_flags = fl; opnd_a = a; opnd_b = b;
    acc_in = c; acc_hi = h; acc_lo = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble all inputs right after the start edge
    op = ~o; set_flags = ~fl; opnd_a = ~a; opnd_b = b ^ 32'h5A5A5A5A;
    acc_in = ~c; acc_hi = ~h; acc_lo = ~l;
    chk(busy === 1'b1, "R9", "busy after start", {63'd0, busy}, 64'd1);
    n = 0;
    while (done !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
      start = (n == poke_at);
    end
    start = 1'b0;
    chk(n == LATENCY, "R9", "latency", 64'(n), 64'(LATENCY));
    chk({res_hi, res_lo} === exp_r, rq, "result", {res_hi, res_lo}, exp_r);
    chk(flag_n === exp_n && flag_z === exp_z, fl ? "R6" : "R7", "flags",
        {62'd0, flag_n, flag_z}, {62'd0, exp_n, exp_z});
    @(negedge clk);
    chk(done === 1'b0, "R9", "done single cycle", {63'd0, done}, 64'd0);
    chk(busy === 1'b0, "R9", "idle after done", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs zero under reset
    chk({res_hi, res_lo, flag_n, flag_z, done, busy, err} === '0, "R11",
        "reset outputs", {res_hi, res_lo}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({res_hi, res_lo, flag_n, flag_z, done, busy, err} === '0, "R11",
        "after reset", {res_hi, res_lo}, 64'd0);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].op, VECS[i].fl, VECS[i].a, VECS[i].b, VECS[i].c,
             VECS[i].hi, VECS[i].lo, -1);

    // R10: start pulse in mid-flight is ignored
    run_op(3'b111, 1'b1, 32'h0000ABCD, 32'hFFFF0001, 32'd0, 32'h00000001,
           32'hFFFFFFFF, 5);
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (done === 1'b1) extra++;
      end
      chk(extra == 0, "R10", "no second done", 64'(extra), 64'd0);
    end

    // R8: unassigned opcodes
    for (int j = 2; j < 4; j++) begin
      logic [63:0] keep_r;
      logic [1:0]  keep_f;
      int ndone;
      keep_r = {res_hi, res_lo};
      keep_f = {flag_n, flag_z};
      @(negedge clk);
      op = 3'(j); set_flags = 1'b1; opnd_a = 32'd9; opnd_b = 32'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err === 1'b1 && busy === 1'b0, "R8", "err strobe", {62'd0, err, busy}, 64'd2);
      ndone = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (done === 1'b1 || err === 1'b1) ndone++;
      end
      chk(ndone == 0, "R8", "no done/err after", 64'(ndone), 64'd0);
      chk({res_hi, res_lo} === keep_r && {flag_n, flag_z} === keep_f, "R8",
          "results held", {res_hi, res_lo}, keep_r);
    end

    // random operands over all legal opcodes
    for (int i = 0; i < 36; i++) begin
      logic [2:0] o;
      case (i % 6)
        0: o = 3'b000;  1: o = 3'b001;  2: o = 3'b100;
        3: o = 3'b101;  4: o = 3'b110;  default: o = 3'b111;
      endcase
      run_op(o, 1'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom, -1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule